// File: doc/BRIEF.md
# Dual-Clock Queue with Selectable Read Timing

This block is a first-in first-out queue of 9-bit words that joins two unrelated clock domains. A producer pushes words with its own clock and enable, and a consumer pulls them with a separate clock and enable, so the two sides run at independent rates. Pointers pass between the domains as Gray codes through two-flop synchronisers. Full, half-full and almost-full are computed on the write side. Empty and almost-empty are computed on the read side.

The read timing is fixed when master reset ends. Standard timing needs a read enable for every word, and it reports full and empty. Fall-through timing presents the oldest word on the output as soon as it reaches the read side, with no enable. In this timing the two status pins mean "output word valid" and "room to write". The two thresholds for the almost flags can be reprogrammed through a parallel configuration port on the write clock. Master reset restores their default values. Partial reset empties the queue but keeps both the thresholds and the timing mode.

Top module: `dcq_fifo`

## Requirements
- R1: Words leave the queue in the order in which they were accepted, with their values unchanged. In standard timing, a read enable sampled while the queue holds data loads the oldest word onto `rd_data` at that rising read clock.
- R2: In standard timing, `rd_data` changes only on a rising read clock where a word is read. After reset `rd_data` is 0, and `rd_flag` is 1 exactly when no word is stored.
- R3: In fall-through timing, the oldest word appears on `rd_data` with `rd_flag` = 1 and no read enable. A read enable sampled while `rd_flag` = 1 replaces it with the next word. If no next word is stored, `rd_flag` drops to 0 instead.
- R4: In fall-through timing, `rd_flag` means "output word valid" and `wr_flag` means "room to write". With 16 words stored plus one held on the output, `wr_flag` = 0.
- R5: In standard timing, `wr_flag` is the full flag and is 1 when DEPTH (16) words are stored. A write while full is ignored and does not change the queue contents.
- R6: A read enable while the queue is empty is ignored. `rd_data` and the read pointer keep their values, and the next stored word is the next one read.
- R7: `half_full` is 1 when the stored count is at least DEPTH/2 (8).
- R8: `almost_empty` is 1 when the stored count is at or below the empty threshold, which defaults to 2. In fall-through timing the stored count includes the word held on the output.
- R9: `almost_full` is 1 when the free space (DEPTH minus the stored count) is at or below the full threshold, which defaults to 2.
- R10: When `cfg_we` = 1 on a rising write clock, `cfg_val` is loaded into the threshold that `cfg_sel` selects: 0 selects the empty threshold and 1 selects the full threshold.
- R11: A low pulse on `prst_n` empties the queue but keeps both programmed thresholds and the timing mode. `mode_sel` is ignored during a partial reset.
- R12: A low pulse on `mrst_n` empties the queue and restores both thresholds to their defaults. It also captures the timing from `mode_sel` as held when the reset ends: 0 selects standard and 1 selects fall-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low |
| mode_sel | input | 1 | Read timing captured at master reset (0 standard, 1 fall-through) |
| wr_en | input | 1 | Write enable |
| wr_data | input | 9 | Word to write |
| cfg_we | input | 1 | Threshold load strobe (write clock) |
| cfg_sel | input | 1 | Threshold select: 0 empty side, 1 full side |
| cfg_val | input | 4 | Threshold value |
| rd_en | input | 1 | Read enable |
| rd_data | output | 9 | Output word |
| wr_flag | output | 1 | Full (standard) or room-to-write (fall-through) |
| rd_flag | output | 1 | Empty (standard) or output-valid (fall-through) |
| half_full | output | 1 | Stored count at least half the depth |
| almost_full | output | 1 | Free space at or below the full threshold |
| almost_empty | output | 1 | Stored count at or below the empty threshold |

## Verification
The write-side flags and the write path can both be active on one write edge. A write that lands on a full queue has to be dropped in the same cycle in which the full, half-full and almost-full flags are evaluated. The bench provokes this by filling the queue one word at a time and sampling each flag after the exact write that should flip it. It then issues one more write with a distinct marker value and drains the queue, so that the marker must be missing from the output. On the read side, a fall-through pop can coincide with the memory running dry. This case is judged by checking that the valid flag drops on the pop that consumes the last word and that the output holds the correct value until that pop.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rmode_t;
endpackage

// File: rtl/dcq_rst_sync.sv
module dcq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dcq_sync.sv
module dcq_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= din;
      hold_q <= meta_q;
    end
  end

  assign dout = hold_q;
endmodule

// File: rtl/dcq_wr_ctl.sv
module dcq_wr_ctl
  import dcq_pkg::*;
#(
  parameter int AW     = 4,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wmrst_n,
  input  logic          mode_in,
  input  logic          wen,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_val,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_do,
  output logic          wr_flag,
  output logic          half_full,
  output logic          almost_full,
  output logic [AW-1:0] ae_off
);
  localparam logic [AW:0]   DEPTH_V = (AW+1)'(1 << AW);
  localparam logic [AW:0]   HALF_V  = (AW+1)'(1 << (AW-1));
  localparam logic [AW-1:0] AE_INIT = AW'(AE_DEF);
  localparam logic [AW-1:0] AF_INIT = AW'(AF_DEF);

  rmode_t        mode_q;
  logic [AW:0]   wbin_q, wbin_d, wgray_q, wgray_d;
  logic [AW:0]   rbin_s, wcount, free_cnt;
  logic [AW-1:0] ae_q, ae_d, af_q, af_d;
  logic          full;

  // Timing mode follows mode_in while master reset is held in this domain
  always_ff @(posedge wclk) begin
    if (!wmrst_n) mode_q <= rmode_t'(mode_in);
  end

  always_comb begin
    for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign wcount   = wbin_q - rbin_s;
  assign full     = (wcount == DEPTH_V);
  assign free_cnt = DEPTH_V - wcount;
  assign wr_do    = wen && !full;

  always_comb begin
    wbin_d  = wbin_q + (AW+1)'(wr_do);
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_comb begin
    ae_d = ae_q;
    af_d = af_q;
    if (cfg_we) begin
      if (cfg_sel) af_d = cfg_val;
      else         ae_d = cfg_val;
    end
  end

  always_ff @(posedge wclk or negedge wmrst_n) begin
    if (!wmrst_n) begin
      ae_q <= AE_INIT;
      af_q <= AF_INIT;
    end else begin
      ae_q <= ae_d;
      af_q <= af_d;
    end
  end

  assign wgray       = wgray_q;
  assign waddr       = wbin_q[AW-1:0];
  assign ae_off      = ae_q;
  assign half_full   = (wcount >= HALF_V);
  assign almost_full = (free_cnt <= {1'b0, af_q});
  assign wr_flag     = (mode_q == MODE_FWFT) ? !full : full;

  assert_no_overflow_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    wcount <= DEPTH_V);

  assert_full_write_dropped_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wen && full) |=> (wbin_q == $past(wbin_q)));

  assert_full_implies_af_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> almost_full);
endmodule

// File: rtl/dcq_rd_ctl.sv
module dcq_rd_ctl
  import dcq_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rmrst_n,
  input  logic          mode_in,
  input  logic          ren,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rdata,
  output logic          rd_flag,
  output logic          almost_empty
);
  rmode_t        mode_q;
  logic [AW:0]   rbin_q, rbin_d, rgray_q, rgray_d;
  logic [AW:0]   wbin_s, mem_cnt, rcount;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          valid_q, valid_d, pop, mem_empty, fwft;

  always_ff @(posedge rclk) begin
    if (!rmrst_n) mode_q <= rmode_t'(mode_in);
  end

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign mem_cnt   = wbin_s - rbin_q;
  assign mem_empty = (mem_cnt == '0);
  assign fwft      = (mode_q == MODE_FWFT);

  always_comb begin
    pop     = 1'b0;
    valid_d = valid_q;
    rdata_d = rdata_q;
    if (fwft) begin
      if ((!valid_q || ren) && !mem_empty) begin
        pop     = 1'b1;
        valid_d = 1'b1;
        rdata_d = mem_rdata;
      end else if (ren) begin
        valid_d = 1'b0;
      end
    end else if (ren && !mem_empty) begin
      pop     = 1'b1;
      rdata_d = mem_rdata;
    end
    rbin_d  = rbin_q + (AW+1)'(pop);
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      rdata_q <= rdata_d;
      valid_q <= valid_d;
    end
  end

  assign rcount       = mem_cnt + (AW+1)'(valid_q);
  assign almost_empty = (rcount <= {1'b0, ae_off});
  assign rd_flag      = fwft ? valid_q : mem_empty;
  assign raddr        = rbin_q[AW-1:0];
  assign rgray        = rgray_q;
  assign rdata        = rdata_q;

  assert_empty_read_ignored_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!fwft && mem_empty && ren) |=> (rbin_q == $past(rbin_q)));

  assert_std_hold_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!fwft && !ren) |=> $stable(rdata));

  assert_fwft_hold_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
    (fwft && valid_q && !ren) |=> (valid_q && $stable(rdata)));

  assert_mode_kept_R11: assert property (@(posedge rclk) disable iff (!rmrst_n)
    1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/dcq_fifo.sv
module dcq_fifo #(
  parameter int AW     = 4,
  parameter int DW     = 9,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_val,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          wr_flag,
  output logic          rd_flag,
  output logic          half_full,
  output logic          almost_full,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;

  logic          any_rst_n;
  logic          wrst_n, wmrst_n, rrst_n, rmrst_n;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr, ae_off;
  logic          wr_do;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_rdata;

  assign any_rst_n = mrst_n & prst_n;

  dcq_rst_sync u_wrst  (.clk(wr_clk), .arst_n(any_rst_n), .srst_n(wrst_n));
  dcq_rst_sync u_wmrst (.clk(wr_clk), .arst_n(mrst_n),    .srst_n(wmrst_n));
  dcq_rst_sync u_rrst  (.clk(rd_clk), .arst_n(any_rst_n), .srst_n(rrst_n));
  dcq_rst_sync u_rmrst (.clk(rd_clk), .arst_n(mrst_n),    .srst_n(rmrst_n));

  dcq_sync #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .din(wgray), .dout(wgray_s));
  dcq_sync #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .din(rgray), .dout(rgray_s));

  dcq_wr_ctl #(.AW(AW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .wclk(wr_clk), .wrst_n(wrst_n), .wmrst_n(wmrst_n), .mode_in(mode_sel),
    .wen(wr_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .wr_do(wr_do),
    .wr_flag(wr_flag), .half_full(half_full), .almost_full(almost_full),
    .ae_off(ae_off)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_do) mem[waddr] <= wr_data;
  end

  assign mem_rdata = mem[raddr];

  dcq_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .rclk(rd_clk), .rrst_n(rrst_n), .rmrst_n(rmrst_n), .mode_in(mode_sel),
    .ren(rd_en), .wgray_s(wgray_s), .ae_off(ae_off), .mem_rdata(mem_rdata),
    .raddr(raddr), .rgray(rgray), .rdata(rd_data), .rd_flag(rd_flag),
    .almost_empty(almost_empty)
  );
endmodule

// File: tb/tb_dcq_fifo.sv
module tb_dcq_fifo;
  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       mrst_n, prst_n, mode_sel, wr_en, rd_en, cfg_we, cfg_sel;
  logic [8:0] wr_data;
  logic [3:0] cfg_val;
  logic [8:0] rd_data;
  logic       wr_flag, rd_flag, half_full, almost_full, almost_empty;
  int         checks = 0;
  int         errors = 0;

  always #5 wr_clk = ~wr_clk;
  always #8 rd_clk = ~rd_clk;

  dcq_fifo dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_val(cfg_val), .rd_en(rd_en), .rd_data(rd_data),
    .wr_flag(wr_flag), .rd_flag(rd_flag), .half_full(half_full),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic push(input logic [8:0] v);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pull();
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic program_off(input logic sel, input logic [3:0] v);
    @(negedge wr_clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_val = v;
    @(negedge wr_clk);
    cfg_we = 1'b0;
  endtask

  task automatic master_reset(input logic m);
    mrst_n = 1'b0; mode_sel = m;
    repeat (4) @(negedge rd_clk);
    mrst_n = 1'b1;
    settle();
  endtask

  task automatic partial_reset();
    prst_n = 1'b0;
    repeat (4) @(negedge rd_clk);
    prst_n = 1'b1;
    settle();
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 11) & 9'h1FF);
  endfunction

  task automatic t_reset_state();
    master_reset(1'b0);
    chk("R12", "empty after reset", rd_flag, 1);
    chk("R12", "full after reset", wr_flag, 0);
    chk("R7", "half_full after reset", half_full, 0);
    chk("R9", "almost_full after reset", almost_full, 0);
    chk("R8", "almost_empty after reset", almost_empty, 1);
    chk("R2", "rd_data after reset", rd_data, 0);
  endtask

  task automatic t_std_order();
    for (int i = 0; i < 5; i++) push(9'h0A0 + 9'(i));
    settle();
    chk("R2", "rd_data held before read", rd_data, 0);
    chk("R2", "not empty", rd_flag, 0);
    for (int i = 0; i < 5; i++) begin
      pull();
      chk("R1", "std order", rd_data, 9'h0A0 + 9'(i));
    end
    chk("R2", "empty after drain", rd_flag, 1);
  endtask

  task automatic t_empty_read();
    pull();
    pull();
    chk("R6", "rd_data held on empty read", rd_data, 9'h0A4);
    push(9'h055);
    settle();
    pull();
    chk("R6", "next word after empty reads", rd_data, 9'h055);
    chk("R6", "empty again", rd_flag, 1);
  endtask

  task automatic t_fill_flags();
    for (int i = 0; i < 16; i++) begin
      push(pat(i));
      if (i == 6)  chk("R7", "half_full at 7", half_full, 0);
      if (i == 7)  chk("R7", "half_full at 8", half_full, 1);
      if (i == 12) chk("R9", "almost_full at 13", almost_full, 0);
      if (i == 13) chk("R9", "almost_full at 14", almost_full, 1);
      if (i == 14) chk("R5", "full at 15", wr_flag, 0);
      if (i == 15) chk("R5", "full at 16", wr_flag, 1);
    end
    push(9'h1FF);
    settle();
    chk("R5", "full held after extra write", wr_flag, 1);
    for (int i = 0; i < 16; i++) begin
      pull();
      chk("R5", "drain after full", rd_data, pat(i));
      if (i == 12) chk("R8", "almost_empty with 3 left", almost_empty, 0);
      if (i == 13) chk("R8", "almost_empty with 2 left", almost_empty, 1);
    end
    chk("R5", "extra write absent", rd_flag, 1);
  endtask

  task automatic t_program();
    program_off(1'b0, 4'd5);
    program_off(1'b1, 4'd4);
    for (int i = 0; i < 5; i++) push(9'h010 + 9'(i));
    settle();
    chk("R10", "almost_empty at 5 with offset 5", almost_empty, 1);
    push(9'h015);
    settle();
    chk("R10", "almost_empty at 6 with offset 5", almost_empty, 0);
    for (int i = 6; i < 11; i++) push(9'h010 + 9'(i));
    chk("R10", "almost_full at 11 with offset 4", almost_full, 0);
    push(9'h01B);
    chk("R10", "almost_full at 12 with offset 4", almost_full, 1);
  endtask

  task automatic t_partial();
    mode_sel = 1'b1;
    partial_reset();
    chk("R11", "empty after partial reset", rd_flag, 1);
    chk("R11", "not full after partial reset", wr_flag, 0);
    for (int i = 0; i < 5; i++) push(9'h020 + 9'(i));
    settle();
    chk("R11", "empty offset kept", almost_empty, 1);
    chk("R11", "std mode kept, rd_data not fallen through", rd_data, 0);
    for (int i = 5; i < 12; i++) push(9'h020 + 9'(i));
    chk("R11", "full offset kept", almost_full, 1);
    partial_reset();
  endtask

  task automatic t_fwft();
    master_reset(1'b1);
    chk("R4", "room to write after reset", wr_flag, 1);
    chk("R4", "no valid word after reset", rd_flag, 0);
    push(9'h111); push(9'h122); push(9'h133);
    settle();
    chk("R12", "default empty offset restored", almost_empty, 0);
    chk("R3", "first word falls through", rd_data, 9'h111);
    chk("R3", "valid without read enable", rd_flag, 1);
    pull();
    chk("R3", "second word", rd_data, 9'h122);
    pull();
    chk("R3", "third word", rd_data, 9'h133);
    pull();
    chk("R4", "valid drops when drained", rd_flag, 0);
    for (int i = 0; i < 17; i++) push(pat(i + 40));
    settle();
    chk("R4", "no room with 16 stored plus output", wr_flag, 0);
    push(9'h1FF);
    settle();
    for (int i = 0; i < 17; i++) begin
      chk("R3", "fwft drain order", rd_data, pat(i + 40));
      pull();
    end
    chk("R4", "valid low after full drain", rd_flag, 0);
  endtask

  task automatic t_prst_mode();
    mode_sel = 1'b0;
    partial_reset();
    push(9'h0C3);
    settle();
    chk("R11", "fall-through kept after partial reset", rd_flag, 1);
    chk("R11", "word presented without read enable", rd_data, 9'h0C3);
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mrst_n = 1'b0; prst_n = 1'b1; mode_sel = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_val = '0;
    t_reset_state();
    t_std_order();
    t_empty_read();
    t_fill_flags();
    t_program();
    t_partial();
    t_fwft();
    t_prst_mode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule